// File: doc/BRIEF.md
# Next-Run Fetch Address Predictor

This block guesses where instruction fetch goes after the current run of sequential instructions. The only input it needs is the address at which that run begins. It folds two fields of that address together with XOR to form a table index. The selected entry carries a tag and one predicted target for each branch slot in the fetch block. A separate direction predictor supplies one taken bit per slot. The block returns the target of the first slot that is both predicted taken and holds a valid target. If no such slot exists, it returns the address of the next sequential fetch block.

The fetch unit presents the predicted address back as the next lookup address. For this reason the lookup is purely combinational: the result is ready in the same cycle as the address, so no fetch cycle is lost after a predicted-taken branch. Resolved targets come back through an update port. That port either fills one slot of an entry whose tag matches, or claims the entry for a new run.

Top module: `ntp_next_run_predictor`

## Requirements
- R1: The table index is the XOR of lookup address bits [7:2] and bits [13:8]. The tag is bits [31:8]. A lookup hits only when the indexed entry is valid and its tag equals the tag of the lookup address, so two addresses that share an index but differ in tag never hit on each other's data.
- R2: On a hit with exactly one usable slot predicted taken, `pred_addr` equals that slot's stored target and `pred_hit` is 1. Bit i of `lk_taken` belongs to slot i.
- R3: When more than one usable slot is predicted taken, the usable slot with the lowest number supplies `pred_addr`.
- R4: A taken bit on a slot that has no valid target is ignored. It neither raises `pred_hit` nor changes `pred_addr`.
- R5: On a miss, `pred_addr` equals `lk_addr + 16` (four 4-byte instructions) and `pred_hit` is 0, whatever `lk_taken` holds.
- R6: On a hit where no usable slot is predicted taken, `pred_addr` equals `lk_addr + 16` and `pred_hit` is 0.
- R7: An update whose address tag matches a valid entry writes `upd_target` into slot `upd_slot` and marks that slot valid. It may overwrite an existing target. The other slots of the entry are left unchanged.
- R8: An update whose tag differs from the entry's tag, or that lands on an invalid entry, claims the entry with the new tag. Only slot `upd_slot` is valid afterwards.
- R9: When an update and a lookup address the same index in the same cycle, the lookup result already reflects the update.
- R10: A synchronous reset (`rst` high at a rising edge) invalidates every entry.
- R11: The lookup result depends only on the current inputs and the table state. It is valid in the same cycle the lookup address is applied, and an update becomes part of the table state at the next rising edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Start address of the current run |
| lk_taken | input | 4 | Per-slot taken predictions, bit i for slot i |
| pred_addr | output | 32 | Predicted start address of the next run |
| pred_hit | output | 1 | A stored target was selected |
| upd_en | input | 1 | Write a resolved target this cycle |
| upd_addr | input | 32 | Run start address of the resolved branch |
| upd_slot | input | 2 | Slot index of the resolved branch |
| upd_target | input | 32 | Resolved target address |

## Verification
Lookup results are combinational, so each lookup check drives the address and taken vector just after a falling edge and samples both outputs 2 ns later, still inside the same cycle. Updates are driven after a falling edge and take effect at the following rising edge. The bench applies each update to its own model at that edge and makes its next lookup in a later cycle. The one exception is the same-cycle test: there the update and the lookup are driven together, the expected result is computed from the model with the update already applied, and the sample is taken before the edge that commits the update.

// File: rtl/ntp_pkg.sv
package ntp_pkg;
    localparam int ADDR_W      = 32;
    localparam int ENTRIES     = 64;
    localparam int SLOTS       = 4;
    localparam int INSN_BYTES  = 4;
    localparam int IDX_W       = $clog2(ENTRIES);
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int OFS_W       = $clog2(INSN_BYTES);
    localparam int TAG_LSB     = OFS_W + IDX_W;
    localparam int TAG_W       = ADDR_W - TAG_LSB;
    localparam int BLOCK_BYTES = SLOTS * INSN_BYTES;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        tag_t                    tag;
        logic [SLOTS-1:0]        svld;
        logic [SLOTS-1:0][ADDR_W-1:0] tgt;
    } entry_t;
endpackage

// File: rtl/ntp_hash.sv
module ntp_hash
    import ntp_pkg::*;
(
    input  logic [ADDR_W-1:OFS_W] addr,
    output idx_t                  idx,
    output tag_t                  tag
);
    // Fold the low index field with the field just above it.
    assign idx = addr[TAG_LSB-1:OFS_W] ^ addr[TAG_LSB+IDX_W-1:TAG_LSB];
    assign tag = addr[ADDR_W-1:TAG_LSB];
endmodule

// File: rtl/ntp_table.sv
module ntp_table
    import ntp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idx_t   lk_idx,
    output logic   lk_vld,
    output entry_t lk_ent,
    input  logic   upd_en,
    input  idx_t   upd_idx,
    input  tag_t   upd_tag,
    input  slot_t  upd_slot,
    input  addr_t  upd_tgt
);
    logic [ENTRIES-1:0] vld_q;
    entry_t             mem_q [ENTRIES];
    entry_t             cur;
    entry_t             merged;
    logic               same_run;
    logic               bypass;

    // Merge the update into the entry it addresses.
    always_comb begin
        cur      = mem_q[upd_idx];
        same_run = vld_q[upd_idx] && (cur.tag == upd_tag);
        merged   = cur;
        if (!same_run) begin
            merged.tag  = upd_tag;
            merged.svld = '0;
        end
        merged.svld[upd_slot] = 1'b1;
        merged.tgt[upd_slot]  = upd_tgt;
    end

    // Write-first forwarding to a same-index lookup.
    assign bypass = upd_en && (upd_idx == lk_idx);
    assign lk_vld = bypass || vld_q[lk_idx];
    assign lk_ent = bypass ? merged : mem_q[lk_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (upd_en) begin
            vld_q[upd_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en && !rst) begin
            mem_q[upd_idx] <= merged;
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (vld_q == '0)); // R10
    AST_UPD_STORED: assert property (@(posedge clk) disable iff (rst) upd_en |=> (vld_q[$past(upd_idx)] && mem_q[$past(upd_idx)].svld[$past(upd_slot)] && (mem_q[$past(upd_idx)].tgt[$past(upd_slot)] == $past(upd_tgt)))); // R7
    AST_REALLOC_ONE: assert property (@(posedge clk) disable iff (rst) (upd_en && !same_run) |=> ($countones(mem_q[$past(upd_idx)].svld) == 1)); // R8
endmodule

// File: rtl/ntp_select.sv
module ntp_select
    import ntp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ent_hit,
    input  logic [SLOTS-1:0]            svld,
    input  logic [SLOTS-1:0][ADDR_W-1:0] tgt,
    input  logic [SLOTS-1:0]            taken,
    input  addr_t                       fall_addr,
    output addr_t                       pred_addr,
    output logic                        pred_hit
);
    logic [SLOTS-1:0] cand;
    logic [SLOTS-1:0] grant;

    assign cand = taken & svld & {SLOTS{ent_hit}};

    // Fixed priority: lowest usable slot wins.
    for (genvar i = 0; i < SLOTS; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign grant[i] = cand[i];
        end else begin : g_rest
            assign grant[i] = cand[i] && !(|cand[i-1:0]);
        end
    end

    always_comb begin
        pred_addr = fall_addr;
        for (int i = 0; i < SLOTS; i++) begin
            if (grant[i]) pred_addr = tgt[i];
        end
    end

    assign pred_hit = |grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R3
    AST_GRANT_USABLE: assert property (@(posedge clk) disable iff (rst) ((grant & ~(taken & svld)) == '0)); // R4
    AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (rst) !ent_hit |-> !pred_hit); // R5
endmodule

// File: rtl/ntp_next_run_predictor.sv
module ntp_next_run_predictor
    import ntp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [SLOTS-1:0]  lk_taken,
    output logic [ADDR_W-1:0] pred_addr,
    output logic              pred_hit,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [SLOT_W-1:0] upd_slot,
    input  logic [ADDR_W-1:0] upd_target
);
    idx_t   lk_idx, upd_idx;
    tag_t   lk_tag, upd_tag;
    logic   lk_vld;
    entry_t lk_ent;
    logic   ent_hit;
    addr_t  fall_addr;

    ntp_hash u_lk_hash  (.addr(lk_addr[ADDR_W-1:OFS_W]),  .idx(lk_idx),  .tag(lk_tag));
    ntp_hash u_upd_hash (.addr(upd_addr[ADDR_W-1:OFS_W]), .idx(upd_idx), .tag(upd_tag));

    ntp_table u_table (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_vld(lk_vld), .lk_ent(lk_ent),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_tag(upd_tag),
        .upd_slot(upd_slot), .upd_tgt(upd_target)
    );

    assign ent_hit   = lk_vld && (lk_ent.tag == lk_tag);
    assign fall_addr = lk_addr + addr_t'(BLOCK_BYTES);

    ntp_select u_select (
        .clk(clk), .rst(rst),
        .ent_hit(ent_hit), .svld(lk_ent.svld), .tgt(lk_ent.tgt),
        .taken(lk_taken), .fall_addr(fall_addr),
        .pred_addr(pred_addr), .pred_hit(pred_hit)
    );

    AST_HIT_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (rst) pred_hit |-> (lk_taken != '0)); // R6
    AST_RESET_MISS: assert property (@(posedge clk) disable iff (rst) ($past(rst) && !upd_en) |-> !pred_hit); // R10
endmodule

// File: tb/tb_ntp_next_run_predictor.sv
module tb_ntp_next_run_predictor;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_addr;
    logic [3:0]  lk_taken;
    logic [31:0] pred_addr;
    logic        pred_hit;
    logic        upd_en;
    logic [31:0] upd_addr;
    logic [1:0]  upd_slot;
    logic [31:0] upd_target;

    always #10 clk = ~clk;

    ntp_next_run_predictor dut (
        .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_taken(lk_taken),
        .pred_addr(pred_addr), .pred_hit(pred_hit), .upd_en(upd_en),
        .upd_addr(upd_addr), .upd_slot(upd_slot), .upd_target(upd_target)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    bit          mv [64];
    logic [23:0] mt [64];
    logic [3:0]  ms [64];
    logic [31:0] mg [64][4];

    function automatic logic [5:0] h_idx(logic [31:0] a);
        return a[7:2] ^ a[13:8];
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 64; i++) mv[i] = 0;
    endfunction

    function automatic void model_upd(logic [31:0] a, logic [1:0] s, logic [31:0] t);
        logic [5:0] i;
        i = h_idx(a);
        if (!(mv[i] && mt[i] == a[31:8])) begin
            mt[i] = a[31:8];
            ms[i] = 4'b0;
        end
        mv[i] = 1;
        ms[i][s] = 1'b1;
        mg[i][s] = t;
    endfunction

    task automatic compare(string req);
        logic [5:0]  i;
        logic        eh;
        logic [31:0] ea;
        i  = h_idx(lk_addr);
        eh = 0;
        ea = lk_addr + 32'd16;
        if (mv[i] && mt[i] == lk_addr[31:8]) begin
            for (int s = 3; s >= 0; s--) begin
                if (lk_taken[s] && ms[i][s]) begin
                    eh = 1;
                    ea = mg[i][s];
                end
            end
        end
        n_cmp++;
        if (pred_hit !== eh || pred_addr !== ea) begin
            n_bad++;
            $display("FAIL %s addr=%h taken=%b: got hit=%b pred=%h, expected hit=%b pred=%h",
                     req, lk_addr, lk_taken, pred_hit, pred_addr, eh, ea);
        end
    endtask

    task automatic look(logic [31:0] a, logic [3:0] tk, string req);
        @(negedge clk);
        lk_addr  = a;
        lk_taken = tk;
        #2;
        compare(req);
    endtask

    task automatic sweep(logic [31:0] a, string req);
        for (int t = 0; t < 16; t++) look(a, 4'(t), req);
    endtask

    task automatic upd(logic [31:0] a, logic [1:0] s, logic [31:0] t);
        @(negedge clk);
        upd_en = 1; upd_addr = a; upd_slot = s; upd_target = t;
        @(posedge clk);
        model_upd(a, s, t);
        #1;
        upd_en = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        @(posedge clk);
        model_clear();
        #1;
        rst = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; upd_en = 0; upd_addr = 0; upd_slot = 0; upd_target = 0;
        lk_addr = 0; lk_taken = 0;
        model_clear();
        do_reset();

        // R10, R5: empty table misses for every taken pattern
        sweep(32'h0000_1040, "R10 reset miss");
        sweep(32'hFFFF_FFF0, "R5 miss fallback");

        // R2, R3, R4, R6, R11: two-slot entry, all taken patterns
        upd(32'h0000_1040, 2'd2, 32'hA000_0200);
        upd(32'h0000_1040, 2'd0, 32'hA000_0000);
        sweep(32'h0000_1040, "R2 R3 R4 R6 R11 partial entry");

        // R3: full entry, priority among all slots
        upd(32'h0012_3450, 2'd3, 32'hB000_0300);
        upd(32'h0012_3450, 2'd1, 32'hB000_0100);
        upd(32'h0012_3450, 2'd2, 32'hB000_0200);
        upd(32'h0012_3450, 2'd0, 32'hB000_0000);
        sweep(32'h0012_3450, "R3 full entry");

        // R7: overwrite one slot, others kept
        upd(32'h0012_3450, 2'd1, 32'hC111_1110);
        sweep(32'h0012_3450, "R7 overwrite");

        // R1: alias with same index and different tag misses
        sweep(32'h0000_2080, "R1 alias miss");

        // R8: alias claims the entry, old run misses, only new slot valid
        upd(32'h0000_2080, 2'd3, 32'hD000_0300);
        sweep(32'h0000_1040, "R8 evicted");
        sweep(32'h0000_2080, "R8 single slot");

        // R1: wide sweep over many hashed addresses
        for (int k = 0; k < 64; k++)
            upd(32'h4000_0000 + 32'(k) * 32'h104, 2'(k % 4), 32'h8000_0000 + 32'(k) * 32'h1000);
        for (int k = 0; k < 64; k++)
            sweep(32'h4000_0000 + 32'(k) * 32'h104, "R1 R2 hashed sweep");

        // R9: update and lookup to the same index in the same cycle
        for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            upd_en = 1; upd_addr = 32'h0777_0000 + 32'(t) * 32'h4;
            upd_slot = 2'(t % 4); upd_target = 32'hE000_0000 + 32'(t);
            lk_addr = upd_addr; lk_taken = 4'(t) | 4'b0001;
            model_upd(upd_addr, upd_slot, upd_target);
            #2;
            compare("R9 write-first");
            @(posedge clk);
            #1;
            upd_en = 0;
        end

        // R9: update to another index leaves the lookup unchanged
        @(negedge clk);
        upd_en = 1; upd_addr = 32'h0333_0010; upd_slot = 2'd0; upd_target = 32'hF000_0000;
        lk_addr = 32'h0012_3450; lk_taken = 4'b1111;
        #2;
        compare("R9 other index");
        @(posedge clk);
        model_upd(32'h0333_0010, 2'd0, 32'hF000_0000);
        #1;
        upd_en = 0;

        // R10: mid-run reset drops everything
        do_reset();
        sweep(32'h0012_3450, "R10 after reset");
        sweep(32'h0000_2080, "R10 after reset");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule